// File: doc/BRIEF.md
# Vector Gather-Scatter Immediate-Form Decoder

This block takes one 32-bit instruction word from the vector gather-load / scatter-store group that uses an immediate offset, and turns it into the control fields an execution pipe needs. It reports four things about the word. First, whether it is a load or a store, and whether its elements are 32 or 64 bits wide. Second, the destination (data) vector register and the vector register that holds the per-lane base addresses. Third, whether the updated lane addresses are to be written back. Fourth, the signed byte offset to add to every lane address.

The word is presented with a strobe, and the decoded result appears on registered outputs one clock later, together with a matching valid. The block flags a word as illegal in four cases: the bit pattern does not belong to the group, the vector extension is switched off, a register number lies outside the usable bank, or a load names the same register for data and addresses. An illegal result carries all-zero decoded fields, so a consumer never sees stale values behind the flag.

Top module: `vgs_imm_decode`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and is low after reset, when all decoded outputs are zero.
- R2: A word belongs to the group only when bits 31:24 equal 8'b1111_1101, bit 16 is 0, bit 12 is 1 and bits 11:9 equal 3'b111; any other word is reported with `out_illegal` high.
- R3: Bit 20 gives the direction: 1 yields `out_is_load` high, 0 yields a store.
- R4: Bit 8 gives the element width: bits 11:8 = 4'b1110 means 32-bit elements (`out_wide` low), 4'b1111 means 64-bit elements (`out_wide` high).
- R5: `out_dst` is bits 15:13 of the word and `out_areg` is bits 19:17.
- R6: The offset magnitude is the unsigned 7-bit immediate in bits 6:0, shifted left by 2 for 32-bit elements and by 3 for 64-bit elements.
- R7: Bit 23 is the add flag; when it is 0, `out_offset` is the two's-complement negation of the magnitude.
- R8: `out_wb` equals bit 21 of the word.
- R9: A load whose `out_dst` equals `out_areg` is illegal; a store with equal numbers is legal.
- R10: With `vec_en` low, every word is illegal.
- R11: Bit 22 (destination bank extension) or bit 7 (address register bank extension) set puts a register outside the usable bank, and the word is illegal.
- R12: When `out_illegal` is high, `out_is_load`, `out_wide`, `out_wb`, `out_dst`, `out_areg` and `out_offset` are all zero.
- R13: In a cycle with `in_valid` low, changes on `in_word` and `vec_en` do not alter any decoded output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vec_en | input | 1 | Vector extension enabled |
| in_valid | input | 1 | Strobe: `in_word` is to be decoded |
| in_word | input | 32 | Instruction word |
| out_valid | output | 1 | Decoded result valid |
| out_illegal | output | 1 | Word rejected |
| out_is_load | output | 1 | 1 = load, 0 = store |
| out_wide | output | 1 | 1 = 64-bit elements, 0 = 32-bit |
| out_wb | output | 1 | Address writeback requested |
| out_dst | output | 3 | Data vector register |
| out_areg | output | 3 | Address vector register |
| out_offset | output | 32 | Signed byte offset per lane |

## Verification
Legal words cover all four direction and width combinations, with both signs of offset and with the smallest and largest immediates. This separates the shift by 2 from the shift by 3, and also separates negation from plain magnitude. Equal register numbers are tried on a load and on a store, which tells the direction-dependent rule apart from a blanket rule. Single-bit corruptions of each fixed pattern field, the bank extension bits, and a disabled extension show that each rejection cause works on its own. An idle cycle with a changed word shows that the outputs hold.

// File: rtl/vgs_pkg.sv
package vgs_pkg;
  localparam int REG_W   = 3;
  localparam int IMM_W   = 7;
  localparam int SH_NARROW = 2;
  localparam int SH_WIDE   = 3;
  localparam logic [7:0] TOP_PATTERN = 8'b1111_1101;
  localparam logic [2:0] MID_PATTERN = 3'b111;

  typedef struct packed {
    logic             match;
    logic             bank_hi;
    logic             is_load;
    logic             wide;
    logic             add;
    logic             wb;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] areg;
    logic [IMM_W-1:0] imm;
  } vgs_fields_t;
endpackage

// File: rtl/vgs_field_split.sv
module vgs_field_split
  import vgs_pkg::*;
(
  input  logic [31:0] word,
  output vgs_fields_t fields
);
  always_comb begin
    fields.match   = (word[31:24] == TOP_PATTERN) && !word[16] && word[12] &&
                     (word[11:9] == MID_PATTERN);
    fields.bank_hi = word[22] | word[7];
    fields.is_load = word[20];
    fields.wide    = word[8];
    fields.add     = word[23];
    fields.wb      = word[21];
    fields.dst     = word[15:13];
    fields.areg    = word[19:17];
    fields.imm     = word[6:0];
  end
endmodule

// File: rtl/vgs_offset_gen.sv
module vgs_offset_gen
  import vgs_pkg::*;
#(
  parameter int OFF_W = 32
) (
  input  logic [IMM_W-1:0] imm,
  input  logic             wide,
  input  logic             add,
  output logic [OFF_W-1:0] offset
);
  localparam int PAD_W = OFF_W - IMM_W;

  logic [OFF_W-1:0] ext;
  logic [OFF_W-1:0] mag;

  generate
    if (PAD_W > 0) begin : g_pad
      assign ext = {{PAD_W{1'b0}}, imm};
    end else begin : g_trunc
      assign ext = imm[OFF_W-1:0];
    end
  endgenerate

  always_comb begin
    mag    = wide ? (ext << SH_WIDE) : (ext << SH_NARROW);
    offset = add ? mag : (~mag + 1'b1);
  end
endmodule

// File: rtl/vgs_legality.sv
module vgs_legality
  import vgs_pkg::*;
(
  input  vgs_fields_t fields,
  input  logic        vec_en,
  output logic        illegal
);
  logic same_reg_load;

  always_comb begin
    same_reg_load = fields.is_load && (fields.dst == fields.areg);
    illegal       = !fields.match || !vec_en || fields.bank_hi || same_reg_load;
  end
endmodule

// File: rtl/vgs_imm_decode.sv
module vgs_imm_decode
  import vgs_pkg::*;
#(
  parameter int OFF_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vec_en,
  input  logic             in_valid,
  input  logic [31:0]      in_word,
  output logic             out_valid,
  output logic             out_illegal,
  output logic             out_is_load,
  output logic             out_wide,
  output logic             out_wb,
  output logic [REG_W-1:0] out_dst,
  output logic [REG_W-1:0] out_areg,
  output logic [OFF_W-1:0] out_offset
);
  // reset release synchronizer
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  vgs_fields_t      fld;
  logic             ill;
  logic [OFF_W-1:0] off;

  vgs_field_split u_split (.word(in_word), .fields(fld));

  vgs_offset_gen #(.OFF_W(OFF_W)) u_off (
    .imm(fld.imm), .wide(fld.wide), .add(fld.add), .offset(off)
  );

  vgs_legality u_legal (.fields(fld), .vec_en(vec_en), .illegal(ill));

  // next-state
  logic             nxt_illegal, nxt_is_load, nxt_wide, nxt_wb;
  logic [REG_W-1:0] nxt_dst, nxt_areg;
  logic [OFF_W-1:0] nxt_offset;

  always_comb begin
    nxt_illegal = ill;
    nxt_is_load = ill ? 1'b0 : fld.is_load;
    nxt_wide    = ill ? 1'b0 : fld.wide;
    nxt_wb      = ill ? 1'b0 : fld.wb;
    nxt_dst     = ill ? '0 : fld.dst;
    nxt_areg    = ill ? '0 : fld.areg;
    nxt_offset  = ill ? '0 : off;
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_illegal <= 1'b0;
      out_is_load <= 1'b0;
      out_wide    <= 1'b0;
      out_wb      <= 1'b0;
      out_dst     <= '0;
      out_areg    <= '0;
      out_offset  <= '0;
    end else if (in_valid) begin
      out_illegal <= nxt_illegal;
      out_is_load <= nxt_is_load;
      out_wide    <= nxt_wide;
      out_wb      <= nxt_wb;
      out_dst     <= nxt_dst;
      out_areg    <= nxt_areg;
      out_offset  <= nxt_offset;
    end
  end

  // assertions
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> out_valid);
  a_r1_valid_idle: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> !out_valid);
  a_r2_top_mismatch: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && in_word[31:24] != TOP_PATTERN) |=> out_illegal);
  a_r3_direction: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid && !out_illegal) |-> (out_is_load == $past(in_word[20])));
  a_r6_narrow_align: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid && !out_illegal && !out_wide) |-> (out_offset[1:0] == 2'b00));
  a_r9_load_regs_differ: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid && !out_illegal && out_is_load) |-> (out_dst != out_areg));
  a_r10_disabled: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && !vec_en) |=> out_illegal);
  a_r12_illegal_zero: assert property (@(posedge clk) disable iff (!rst_q)
    out_illegal |-> (out_offset == '0 && out_dst == '0 && out_areg == '0 &&
                     !out_is_load && !out_wide && !out_wb));
  a_r13_hold: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> ($stable(out_offset) && $stable(out_illegal) &&
                   $stable(out_dst) && $stable(out_areg)));
endmodule

// File: tb/sim_vgs_imm_decode.sv
module sim_vgs_imm_decode;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vec_en = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic        out_valid, out_illegal, out_is_load, out_wide, out_wb;
  logic [2:0]  out_dst, out_areg;
  logic [31:0] out_offset;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vgs_imm_decode u0 (
    .clk(clk), .rst_n(rst_n), .vec_en(vec_en), .in_valid(in_valid),
    .in_word(in_word), .out_valid(out_valid), .out_illegal(out_illegal),
    .out_is_load(out_is_load), .out_wide(out_wide), .out_wb(out_wb),
    .out_dst(out_dst), .out_areg(out_areg), .out_offset(out_offset)
  );

  function automatic logic [31:0] mk(bit ld, bit wd, bit ad, bit wb,
                                     logic [2:0] d, logic [2:0] a, logic [6:0] imm);
    logic [31:0] w;
    w = 32'hFD00_1E00;            // fixed pattern bits 31:24, 12, 11:9
    w[23] = ad; w[21] = wb; w[20] = ld;
    w[19:17] = a; w[15:13] = d; w[8] = wd; w[6:0] = imm;
    return w;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic send(logic [31:0] w, bit en);
    @(negedge clk);
    in_valid = 1'b1; in_word = w; vec_en = en;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 out_valid", {31'd0, out_valid}, 32'd1);
  endtask

  task automatic expect_all(string req, bit ill, bit ld, bit wd, bit wb,
                            logic [2:0] d, logic [2:0] a, logic [31:0] off);
    chk({req, " illegal"}, {31'd0, out_illegal}, {31'd0, ill});
    chk({req, " load"},    {31'd0, out_is_load}, {31'd0, ld});
    chk({req, " wide"},    {31'd0, out_wide},    {31'd0, wd});
    chk({req, " wb"},      {31'd0, out_wb},      {31'd0, wb});
    chk({req, " dst"},     {29'd0, out_dst},     {29'd0, d});
    chk({req, " areg"},    {29'd0, out_areg},    {29'd0, a});
    chk({req, " offset"},  out_offset,           off);
  endtask

  task automatic t_reset();
    chk("R1 reset valid", {31'd0, out_valid}, 32'd0);
    chk("R1 reset offset", out_offset, 32'd0);
    chk("R1 reset illegal", {31'd0, out_illegal}, 32'd0);
  endtask

  task automatic t_load32_add();   // R3 R4 R5 R6 R8
    send(mk(1, 0, 1, 0, 3'd2, 3'd5, 7'd5), 1);
    expect_all("R6 load32", 0, 1, 0, 0, 3'd2, 3'd5, 32'd20);
  endtask

  task automatic t_store64_sub_max();  // R7 R6 R3 R4
    send(mk(0, 1, 0, 1, 3'd7, 3'd0, 7'd127), 1);
    expect_all("R7 store64", 0, 0, 1, 1, 3'd7, 3'd0, 32'hFFFF_FC08);
  endtask

  task automatic t_load64_wb();    // R8 R4
    send(mk(1, 1, 1, 1, 3'd1, 3'd6, 7'd9), 1);
    expect_all("R8 load64", 0, 1, 1, 1, 3'd1, 3'd6, 32'd72);
  endtask

  task automatic t_store32_sub();  // R7
    send(mk(0, 0, 0, 0, 3'd4, 3'd3, 7'd3), 1);
    expect_all("R7 store32", 0, 0, 0, 0, 3'd4, 3'd3, 32'hFFFF_FFF4);
    send(mk(0, 0, 0, 0, 3'd4, 3'd3, 7'd0), 1);
    expect_all("R7 zero imm", 0, 0, 0, 0, 3'd4, 3'd3, 32'd0);
  endtask

  task automatic t_same_reg();     // R9
    send(mk(1, 0, 1, 0, 3'd3, 3'd3, 7'd1), 1);
    expect_all("R9 load same", 1, 0, 0, 0, 3'd0, 3'd0, 32'd0);
    send(mk(0, 1, 1, 0, 3'd3, 3'd3, 7'd1), 1);
    expect_all("R9 store same", 0, 0, 1, 0, 3'd3, 3'd3, 32'd8);
  endtask

  task automatic t_disabled();     // R10
    send(mk(0, 0, 1, 0, 3'd1, 3'd2, 7'd4), 0);
    expect_all("R10 disabled", 1, 0, 0, 0, 3'd0, 3'd0, 32'd0);
  endtask

  task automatic t_bank();         // R11
    logic [31:0] w;
    w = mk(0, 0, 1, 0, 3'd1, 3'd2, 7'd4); w[22] = 1'b1;
    send(w, 1);
    expect_all("R11 dst bank", 1, 0, 0, 0, 3'd0, 3'd0, 32'd0);
    w = mk(0, 0, 1, 0, 3'd1, 3'd2, 7'd4); w[7] = 1'b1;
    send(w, 1);
    expect_all("R11 areg bank", 1, 0, 0, 0, 3'd0, 3'd0, 32'd0);
  endtask

  task automatic t_nomatch();      // R2 R12
    logic [31:0] base;
    base = mk(0, 0, 1, 1, 3'd1, 3'd2, 7'd4);
    send(base ^ 32'h0100_0000, 1);
    chk("R2 top byte", {31'd0, out_illegal}, 32'd1);
    send(base | 32'h0001_0000, 1);
    chk("R2 bit16", {31'd0, out_illegal}, 32'd1);
    send(base & ~32'h0000_1000, 1);
    expect_all("R12 bit12", 1, 0, 0, 0, 3'd0, 3'd0, 32'd0);
    send(base & ~32'h0000_0400, 1);
    chk("R2 bits11_9", {31'd0, out_illegal}, 32'd1);
  endtask

  task automatic t_hold();         // R13
    send(mk(1, 0, 1, 1, 3'd5, 3'd1, 7'd10), 1);
    @(negedge clk);
    in_word = 32'h0000_0000; vec_en = 1'b0;
    @(negedge clk);
    chk("R13 valid low", {31'd0, out_valid}, 32'd0);
    expect_all("R13 hold", 0, 1, 0, 1, 3'd5, 3'd1, 32'd40);
    vec_en = 1'b1;
  endtask

  task automatic t_back_to_back(); // R1 R5
    @(negedge clk);
    in_valid = 1'b1; in_word = mk(0, 0, 1, 0, 3'd6, 3'd7, 7'd2); vec_en = 1'b1;
    @(negedge clk);
    chk("R1 b2b first", {31'd0, out_valid}, 32'd1);
    chk("R5 b2b dst", {29'd0, out_dst}, 32'd6);
    in_word = mk(0, 0, 1, 0, 3'd0, 3'd4, 7'd2);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 b2b second", {31'd0, out_valid}, 32'd1);
    chk("R5 b2b areg", {29'd0, out_areg}, 32'd4);
    @(negedge clk);
    chk("R1 b2b idle", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_load32_add();
    t_store64_sub_max();
    t_load64_wb();
    t_store32_sub();
    t_same_reg();
    t_disabled();
    t_bank();
    t_nomatch();
    t_hold();
    t_back_to_back();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule